// File: doc/BRIEF.md
# Floating-Point to Signed Integer Converter

This block converts one IEEE single- or double-precision operand into a signed 32-bit or 64-bit integer. Each request names the source format, the destination width and a rounding selection. The selection either forces one of four fixed rounding directions or takes the rounding mode supplied on a separate dynamic-mode input. Out-of-range values, infinities and NaNs have two possible results, and a control bit picks between them. In the standard-2008 policy the result saturates by sign and a NaN gives zero. In the legacy policy every invalid case returns one fixed pattern.

The converter takes one request per cycle, with no stall. A request is presented with `in_valid`. One cycle later the result and the invalid, overflow and inexact flags appear, qualified by `out_valid`. The flags are raised in the same way under both policies. Any trapping on them is left to the surrounding unit.

Top module: `fp2int_cvt`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first request, `out_valid`, `result` and all three flags are 0.
- R2: A request accepted with `in_valid` high shows its result and flags in the following cycle, with `out_valid` high. `out_valid` is low in the cycle after any cycle in which `in_valid` is low.
- R3: With `src_dbl` = 1 the operand is the whole 64-bit double. With `src_dbl` = 0 the operand is the single in `operand[31:0]`, and `operand[63:32]` has no effect on the outputs.
- R4: With `dst_64` = 1 the result is a 64-bit two's-complement integer. With `dst_64` = 0 it is a 32-bit two's-complement integer, sign-extended into `result[63:32]`.
- R5: `rnd_sel` chooses the rounding: 1 = nearest with ties to even, 2 = toward zero, 3 = toward +infinity, 4 = toward -infinity, and 0 (as well as 5 to 7) = the mode on `dyn_rm`. `dyn_rm` is encoded 0 = nearest even, 1 = toward zero, 2 = toward +infinity, 3 = toward -infinity.
- R6: `flag_inexact` is 1 exactly when a finite operand whose rounded value is in range had non-zero bits below the integer point. Zero, subnormal and tiny operands round to 0 or to ±1 as the rounding direction dictates.
- R7: `flag_invalid` is 1 for a NaN, for an infinity, and for a finite operand whose rounded value lies outside the signed destination range. `flag_overflow` is 1 for the same cases except NaN. Both flags are raised under either policy.
- R8: With `nan2008` = 1, an invalid NaN gives 0. Any other invalid case gives the most negative destination integer for a negative sign and the most positive for a positive sign.
- R9: With `nan2008` = 0, every invalid case gives 0x000000007FFFFFFF for a 32-bit destination and 0x7FFFFFFFFFFFFFFF for a 64-bit destination.
- R10: A negative operand that rounds to exactly -2^31 (32-bit) or -2^63 (64-bit) is in range. It yields that value and raises neither invalid nor overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| operand | input | 64 | Floating-point operand (single in bits 31:0) |
| src_dbl | input | 1 | 1 = double source, 0 = single source |
| dst_64 | input | 1 | 1 = 64-bit result, 0 = 32-bit result |
| rnd_sel | input | 3 | Rounding selection (R5 encoding) |
| dyn_rm | input | 2 | Dynamic rounding mode (R5 encoding) |
| nan2008 | input | 1 | 1 = saturating policy, 0 = legacy fixed pattern |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Integer result |
| flag_invalid | output | 1 | Invalid operation |
| flag_overflow | output | 1 | Out-of-range non-NaN operand |
| flag_inexact | output | 1 | Fraction discarded in a valid conversion |

## Verification
The block has no parameters, so the bench builds its only configuration, and that configuration covers all four source and destination pairs. Directed operands hit the boundaries that matter here: exact ±2^31 and -2^63, a value half a unit past -2^31 under each rounding direction, ties under nearest-even, subnormals under the directed modes, and quiet and signalling NaNs and infinities under both policies. Garbage in the upper half of a single operand confirms that half is ignored.

// File: rtl/fp2int_cvt.sv
module fp2int_cvt (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [63:0] operand,
  input  logic        src_dbl,
  input  logic        dst_64,
  input  logic [2:0]  rnd_sel,
  input  logic [1:0]  dyn_rm,
  input  logic        nan2008,
  output logic        out_valid,
  output logic [63:0] result,
  output logic        flag_invalid,
  output logic        flag_overflow,
  output logic        flag_inexact
);

  logic        sign;
  logic [10:0] exp_raw;
  logic [51:0] frac;
  logic        exp_ones, is_sub, is_nan, is_inf;
  logic [10:0] exp_eff;
  logic [12:0] bias;
  logic signed [12:0] pos;
  logic        huge, tiny;
  logic [52:0] sig;
  logic [191:0] wide;
  logic [63:0] int_part;
  logic        rbit, sbit, inc;
  logic [1:0]  rm;
  logic [64:0] mag_r, lim;
  logic        oor, inv, ovf, inx;
  logic [63:0] val, sat, res_n;

  assign sign     = src_dbl ? operand[63] : operand[31];
  assign exp_raw  = src_dbl ? operand[62:52] : {3'b000, operand[30:23]};
  assign frac     = src_dbl ? operand[51:0] : {operand[22:0], 29'b0};
  assign exp_ones = src_dbl ? (exp_raw == 11'h7FF) : (exp_raw == 11'h0FF);
  assign is_sub   = (exp_raw == 11'd0);
  assign is_nan   = exp_ones && (frac != 52'd0);
  assign is_inf   = exp_ones && (frac == 52'd0);

  assign exp_eff = is_sub ? 11'd1 : exp_raw;
  assign bias    = src_dbl ? 13'd1023 : 13'd127;
  assign pos     = $signed({2'b00, exp_eff} + 13'd76 - bias);
  assign huge    = pos > 13'sd139;
  assign tiny    = pos < 13'sd12;
  assign sig     = {~is_sub, frac};
  assign wide    = {139'b0, sig} << pos[7:0];

  assign int_part = tiny ? 64'd0 : wide[191:128];
  assign rbit     = tiny ? 1'b0 : wide[127];
  assign sbit     = tiny ? (sig != 53'd0) : (wide[126:0] != 127'd0);

  always_comb begin
    case (rnd_sel)
      3'd1:    rm = 2'd0;
      3'd2:    rm = 2'd1;
      3'd3:    rm = 2'd2;
      3'd4:    rm = 2'd3;
      default: rm = dyn_rm;
    endcase
  end

  always_comb begin
    case (rm)
      2'd0:    inc = rbit && (sbit || int_part[0]);
      2'd2:    inc = !sign && (rbit || sbit);
      2'd3:    inc = sign && (rbit || sbit);
      default: inc = 1'b0;
    endcase
  end

  assign mag_r = {1'b0, int_part} + {64'd0, inc};
  assign lim   = dst_64 ? (sign ? 65'h0_8000_0000_0000_0000 : 65'h0_7FFF_FFFF_FFFF_FFFF)
                        : (sign ? 65'h0_0000_0000_8000_0000 : 65'h0_0000_0000_7FFF_FFFF);
  assign oor   = huge || (mag_r > lim);

  assign inv = exp_ones || oor;
  assign ovf = is_inf || (!exp_ones && oor);
  assign inx = !inv && (rbit || sbit);

  assign val = sign ? (~mag_r[63:0] + 64'd1) : mag_r[63:0];
  assign sat = is_nan ? 64'd0 :
               dst_64 ? (sign ? 64'h8000_0000_0000_0000 : 64'h7FFF_FFFF_FFFF_FFFF)
                      : (sign ? 64'hFFFF_FFFF_8000_0000 : 64'h0000_0000_7FFF_FFFF);
  assign res_n = !inv ? val :
                 nan2008 ? sat :
                 (dst_64 ? 64'h7FFF_FFFF_FFFF_FFFF : 64'h0000_0000_7FFF_FFFF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      result        <= 64'd0;
      flag_invalid  <= 1'b0;
      flag_overflow <= 1'b0;
      flag_inexact  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result        <= res_n;
        flag_invalid  <= inv;
        flag_overflow <= ovf;
        flag_inexact  <= inx;
      end
    end
  end

endmodule

module fp2int_cvt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        dst_64,
  input logic        nan2008,
  input logic        out_valid,
  input logic [63:0] result,
  input logic        flag_invalid,
  input logic        flag_overflow,
  input logic        flag_inexact
);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2

  AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R2

  AST_SEXT_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(dst_64)) |-> (result[63:32] == {32{result[31]}})); // R4

  AST_INEXACT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(flag_inexact && flag_invalid)); // R6

  AST_OVF_IS_INV: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flag_overflow) |-> flag_invalid); // R7

  AST_NAN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(nan2008) && flag_invalid && !flag_overflow) |-> (result == 64'd0)); // R8

  AST_LEGACY_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(nan2008) && flag_invalid) |->
      (result == ($past(dst_64) ? 64'h7FFF_FFFF_FFFF_FFFF : 64'h0000_0000_7FFF_FFFF))); // R9

endmodule

bind fp2int_cvt fp2int_cvt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dst_64(dst_64), .nan2008(nan2008),
  .out_valid(out_valid), .result(result), .flag_invalid(flag_invalid),
  .flag_overflow(flag_overflow), .flag_inexact(flag_inexact)
);

// File: tb/fp2int_cvt_tb.sv
`timescale 1ns/1ps
module fp2int_cvt_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] operand = 64'd0;
  logic        src_dbl = 1'b0;
  logic        dst_64 = 1'b0;
  logic [2:0]  rnd_sel = 3'd0;
  logic [1:0]  dyn_rm = 2'd0;
  logic        nan2008 = 1'b0;
  logic        out_valid;
  logic [63:0] result;
  logic        flag_invalid, flag_overflow, flag_inexact;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fp2int_cvt u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
    .src_dbl(src_dbl), .dst_64(dst_64), .rnd_sel(rnd_sel), .dyn_rm(dyn_rm),
    .nan2008(nan2008), .out_valid(out_valid), .result(result),
    .flag_invalid(flag_invalid), .flag_overflow(flag_overflow), .flag_inexact(flag_inexact)
  );

  localparam logic [2:0] SEL_DYN = 3'd0, SEL_RNE = 3'd1, SEL_RZ = 3'd2, SEL_UP = 3'd3, SEL_DN = 3'd4;
  localparam logic [63:0] MAX32 = 64'h0000_0000_7FFF_FFFF, MIN32 = 64'hFFFF_FFFF_8000_0000;
  localparam logic [63:0] MAX64 = 64'h7FFF_FFFF_FFFF_FFFF, MIN64 = 64'h8000_0000_0000_0000;

  task automatic check(input string req, input logic [63:0] exp_res,
                       input logic [2:0] exp_flags);
    checks++;
    if (!out_valid || result !== exp_res ||
        {flag_invalid, flag_overflow, flag_inexact} !== exp_flags) begin
      failures++;
      $display("FAIL %s: got v=%0b res=%h ivx=%b, expected v=1 res=%h ivx=%b",
               req, out_valid, result, {flag_invalid, flag_overflow, flag_inexact},
               exp_res, exp_flags);
    end
  endtask

  task automatic conv(input logic [63:0] op, input logic dbl, input logic d64,
                      input logic [2:0] rs, input logic [1:0] rm, input logic n08,
                      input string req, input logic [63:0] exp_res,
                      input logic [2:0] exp_flags);
    @(negedge clk);
    operand = op; src_dbl = dbl; dst_64 = d64; rnd_sel = rs; dyn_rm = rm; nan2008 = n08;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(req, exp_res, exp_flags);
  endtask

  task automatic t_reset;
    checks++;
    if (out_valid !== 1'b0 || result !== 64'd0 ||
        {flag_invalid, flag_overflow, flag_inexact} !== 3'b000) begin
      failures++;
      $display("FAIL R1: got v=%0b res=%h flags=%b, expected all zero",
               out_valid, result, {flag_invalid, flag_overflow, flag_inexact});
    end
  endtask

  task automatic t_latency;
    conv(64'h3F80_0000, 1'b0, 1'b0, SEL_RNE, 2'd0, 1'b1, "R2 one", 64'd1, 3'b000);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      failures++;
      $display("FAIL R2: got out_valid=%0b, expected 0 after idle cycle", out_valid);
    end
  endtask

  task automatic t_rounding;
    conv(64'h3FC0_0000, 1'b0, 1'b1, SEL_RNE, 2'd0, 1'b1, "R5 rne 1.5", 64'd2, 3'b001);
    conv(64'h4020_0000, 1'b0, 1'b1, SEL_RNE, 2'd0, 1'b1, "R5 rne tie 2.5", 64'd2, 3'b001);
    conv(64'h4020_0000, 1'b0, 1'b1, SEL_UP,  2'd0, 1'b1, "R5 ceil 2.5", 64'd3, 3'b001);
    conv(64'h3FC0_0000, 1'b0, 1'b1, SEL_RZ,  2'd0, 1'b1, "R5 trunc 1.5", 64'd1, 3'b001);
    conv(64'hBFC0_0000, 1'b0, 1'b1, SEL_DN,  2'd0, 1'b1, "R5 floor -1.5", 64'hFFFF_FFFF_FFFF_FFFE, 3'b001);
    conv(64'hBFC0_0000, 1'b0, 1'b1, SEL_UP,  2'd0, 1'b1, "R5 ceil -1.5", 64'hFFFF_FFFF_FFFF_FFFF, 3'b001);
    conv(64'h3FC0_0000, 1'b0, 1'b1, SEL_DYN, 2'd3, 1'b1, "R5 dyn down", 64'd1, 3'b001);
    conv(64'h3FC0_0000, 1'b0, 1'b1, SEL_DYN, 2'd2, 1'b1, "R5 dyn up", 64'd2, 3'b001);
    conv(64'h3FC0_0000, 1'b0, 1'b1, SEL_RZ,  2'd2, 1'b1, "R5 forced ignores dyn", 64'd1, 3'b001);
  endtask

  task automatic t_formats;
    conv(64'hDEAD_BEEF_3FC0_0000, 1'b0, 1'b1, SEL_RNE, 2'd0, 1'b1, "R3 upper ignored", 64'd2, 3'b001);
    conv(64'h3FF8_0000_0000_0000, 1'b1, 1'b1, SEL_RNE, 2'd0, 1'b1, "R3 double 1.5", 64'd2, 3'b001);
    conv(64'h4330_0000_0000_0001, 1'b1, 1'b1, SEL_RNE, 2'd0, 1'b1, "R3 double 2^52+1", 64'h0010_0000_0000_0001, 3'b000);
    conv(64'h4F00_0000, 1'b0, 1'b1, SEL_RZ, 2'd0, 1'b1, "R4 single 2^31 to 64", 64'h0000_0000_8000_0000, 3'b000);
    conv(64'hBFC0_0000, 1'b0, 1'b0, SEL_RZ, 2'd0, 1'b1, "R4 sign extend", 64'hFFFF_FFFF_FFFF_FFFF, 3'b000 | 3'b001);
  endtask

  task automatic t_small;
    conv(64'h0000_0001, 1'b0, 1'b0, SEL_UP,  2'd0, 1'b1, "R6 subnormal ceil", 64'd1, 3'b001);
    conv(64'h0000_0001, 1'b0, 1'b0, SEL_RNE, 2'd0, 1'b1, "R6 subnormal rne", 64'd0, 3'b001);
    conv(64'h8000_0001, 1'b0, 1'b0, SEL_DN,  2'd0, 1'b1, "R6 neg subnormal floor", 64'hFFFF_FFFF_FFFF_FFFF, 3'b001);
    conv(64'h8000_0000, 1'b0, 1'b0, SEL_DN,  2'd0, 1'b1, "R6 neg zero exact", 64'd0, 3'b000);
  endtask

  task automatic t_boundary;
    conv(64'hC1E0_0000_0000_0000, 1'b1, 1'b0, SEL_RNE, 2'd0, 1'b1, "R10 exact -2^31", MIN32, 3'b000);
    conv(64'hC3E0_0000_0000_0000, 1'b1, 1'b1, SEL_RNE, 2'd0, 1'b0, "R10 exact -2^63", MIN64, 3'b000);
    conv(64'hC1E0_0000_0010_0000, 1'b1, 1'b0, SEL_RZ,  2'd0, 1'b1, "R10 trunc -2^31-0.5", MIN32, 3'b001);
    conv(64'hC1E0_0000_0010_0000, 1'b1, 1'b0, SEL_RNE, 2'd0, 1'b1, "R10 rne tie -2^31-0.5", MIN32, 3'b001);
    conv(64'hC1E0_0000_0010_0000, 1'b1, 1'b0, SEL_DN,  2'd0, 1'b1, "R8 floor past -2^31", MIN32, 3'b110);
    conv(64'hC1E0_0000_0010_0000, 1'b1, 1'b0, SEL_DN,  2'd0, 1'b0, "R9 floor past -2^31", MAX32, 3'b110);
    conv(64'h41E0_0000_0000_0000, 1'b1, 1'b0, SEL_RNE, 2'd0, 1'b1, "R7 +2^31 to 32", MAX32, 3'b110);
  endtask

  task automatic t_invalid;
    conv(64'hC3F0_0000_0000_0000, 1'b1, 1'b1, SEL_RNE, 2'd0, 1'b1, "R8 -2^64 sat", MIN64, 3'b110);
    conv(64'hC3F0_0000_0000_0000, 1'b1, 1'b1, SEL_RNE, 2'd0, 1'b0, "R9 -2^64 legacy", MAX64, 3'b110);
    conv(64'h7FC0_0000, 1'b0, 1'b0, SEL_RNE, 2'd0, 1'b1, "R8 qnan zero", 64'd0, 3'b100);
    conv(64'h7F80_0001, 1'b0, 1'b1, SEL_RZ,  2'd0, 1'b1, "R8 snan zero", 64'd0, 3'b100);
    conv(64'h7FC0_0000, 1'b0, 1'b0, SEL_RNE, 2'd0, 1'b0, "R9 nan legacy", MAX32, 3'b100);
    conv(64'hFF80_0000, 1'b0, 1'b1, SEL_RNE, 2'd0, 1'b1, "R7 -inf sat", MIN64, 3'b110);
    conv(64'h7FF0_0000_0000_0000, 1'b1, 1'b0, SEL_RNE, 2'd0, 1'b0, "R7 +inf legacy", MAX32, 3'b110);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latency();
    t_rounding();
    t_formats();
    t_small();
    t_boundary();
    t_invalid();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule